// File: doc/BRIEF.md
# Bank-Switched Memory Map Controller

This block chooses the responder for every CPU memory cycle in a 64K address space. The candidates are on-board RAM, an on-board boot ROM, and memory on the external bus. Software programs the map through one write-only control register on the I/O bus. Four bits of that register switch the four 16K RAM banks on or off. A switched-off bank hands its address range to the external bus, which lets a system add banked external memory for multi-user work. One bit turns the boot ROM on or off. When the ROM is on, it overlays the top 4K of the address space for reads. When it is off, it takes no address space at all.

After reset the block is in a boot-jump state. In this state every memory read is served by the ROM, with the low address bits used as the ROM offset. The CPU can therefore start at address 0000h and run the boot code. RAM cannot be reached until software writes the control register with the release bit set.

A static configuration input selects a 2K ROM. With a 2K ROM, the image repeats inside the 4K window and the top ROM offset bit is forced to zero.

Top module: `bankmap_ctrl`

## Requirements
- R1: Reset (asynchronous, `rstN` low) sets all four bank enables to 1 and turns the ROM on (`romOn`=1). It also enters the boot-jump state (`jumpActive`=1).
- R2: An I/O write to port address 16h updates the register on the next clock edge. Data bits 3:0 become `bankOn[3:0]`, and `romOn` becomes the inverse of data bit 5. An I/O write to any other port address changes nothing.
- R3: A port-16h write with data bit 6 = 1 clears the boot-jump state. A write with bit 6 = 0 leaves that state unchanged. Only reset sets it again.
- R4: While the boot-jump state is active, every memory read asserts `romSel` at any address and never asserts `ramSel`.
- R5: While the boot-jump state is active, a memory write asserts `extMemEn` and never asserts `ramSel`.
- R6: Outside the boot-jump state, a cycle to bank n asserts `ramSel` when `bankOn[n]`=1, unless R8 applies. Bank n is address bits 15:14, so bank 0 is 0000h–3FFFh and bank 3 is C000h–FFFFh.
- R7: Outside the boot-jump state, a cycle to bank n with `bankOn[n]`=0 asserts `extMemEn`, unless R8 applies.
- R8: With the ROM on and the boot-jump state released, a read in F000h–FFFFh asserts `romSel`, whatever the state of bank 3. A write in that window follows the bank decode of R6 and R7.
- R9: With the ROM off, the window F000h–FFFFh follows the bank decode of R6 and R7 for both reads and writes.
- R10: `romAddr` equals address bits 11:0 when `romIs2k`=0. When `romIs2k`=1, `romAddr` is address bits 10:0 with bit 11 forced to 0.
- R11: With neither `memRd` nor `memWr` asserted, `ramSel`, `romSel` and `extMemEn` are all 0.
- R12: At most one of `ramSel`, `romSel` and `extMemEn` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | CPU memory address |
| memRd | input | 1 | Memory read cycle |
| memWr | input | 1 | Memory write cycle |
| ioWr | input | 1 | I/O write strobe |
| ioAddr | input | 8 | I/O port address |
| ioData | input | 8 | I/O write data |
| romIs2k | input | 1 | 1 selects a 2K ROM mirrored in the 4K window |
| ramSel | output | 1 | On-board RAM responds |
| romSel | output | 1 | Boot ROM responds |
| extMemEn | output | 1 | External bus memory responds |
| romAddr | output | 12 | ROM offset |
| bankOn | output | 4 | Latched bank enables |
| romOn | output | 1 | Latched ROM enable |
| jumpActive | output | 1 | Boot-jump state |

## Verification
The bench targets the following corner cases:
- **Boot-jump escape.** A register write with bit 6 clear must not release the jump state. A design that keys release on any write would expose RAM before the boot code is ready.
- **Misdecoded port.** A write to a neighbouring port must change nothing. A design with a loose port compare would silently remap memory.
- **ROM overlay at the top of memory.** The ROM must win over bank 3 for reads only, and must still answer reads when bank 3 is off. A design that gets the priority wrong would send reads to RAM or to the external bus, and one that overlays writes would drop stores to shadow RAM.
- **Mirroring and idle decode.** With a 2K ROM, address bit 11 must not reach the ROM offset. During idle bus cycles no select may be asserted.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Strobes passed from the control side to the datapath side.
  typedef struct packed {
    logic cfgLoad;   // control register write this cycle
    logic bootHold;  // boot-jump state active
  } mapStrobe_t;

endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int IO_AW = 8,
  parameter logic [IO_AW-1:0] CTL_PORT = 8'h16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioWr,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             releaseBit,
  output mapStrobe_t       strobe
);

  logic portHit;
  logic jumpQ;

  assign portHit = ioWr && (ioAddr == CTL_PORT);

  // Boot-jump latch: set by reset, cleared only by a port write with the release bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      jumpQ <= 1'b1;
    else if (portHit && releaseBit)
      jumpQ <= 1'b0;
  end

  always_comb begin
    strobe.cfgLoad  = portHit;
    strobe.bootHold = jumpQ;
  end

  // R3: the jump state holds unless a qualified release write arrives.
  assert_jump_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (jumpQ && !(ioWr && ioAddr == CTL_PORT && releaseBit)) |=> jumpQ);

  // R3: once released, only reset brings the jump state back.
  assert_jump_no_reentry_R3: assert property (@(posedge clk) disable iff (!rstN)
    !jumpQ |=> !jumpQ);

endmodule

// File: rtl/memmap_datapath.sv
module memmap_datapath
  import memmap_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_COUNT = 4,
  parameter int ROM_AW     = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mapStrobe_t            strobe,
  input  logic [BANK_COUNT-1:0] bankData,
  input  logic                  romOffData,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  memRd,
  input  logic                  memWr,
  input  logic                  romIs2k,
  output logic                  ramSel,
  output logic                  romSel,
  output logic                  extMemEn,
  output logic [ROM_AW-1:0]     romAddr,
  output logic [BANK_COUNT-1:0] bankOn,
  output logic                  romOn
);

  localparam int BANK_SEL_W = $clog2(BANK_COUNT);
  localparam int WIN_W      = ADDR_W - ROM_AW;

  logic [BANK_COUNT-1:0] bankReg;
  logic                  romOffReg;
  logic [BANK_COUNT-1:0] bankHit;
  logic                  onboardHit;
  logic                  romWindow;
  logic                  anyCycle;
  logic [ROM_AW-1:0]     romMask;

  // Control register fields; reset leaves all banks on and the ROM on.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankReg   <= '1;
      romOffReg <= 1'b0;
    end else if (strobe.cfgLoad) begin
      bankReg   <= bankData;
      romOffReg <= romOffData;
    end
  end

  // One comparator per bank on the top address bits.
  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    assign bankHit[b] = (cpuAddr[ADDR_W-1 -: BANK_SEL_W] == BANK_SEL_W'(b));
  end

  assign onboardHit = |(bankHit & bankReg);
  assign romWindow  = &cpuAddr[ADDR_W-1 -: WIN_W];
  assign anyCycle   = memRd | memWr;

  // Half-size ROM drops the top offset bit, so the image mirrors.
  always_comb begin
    romMask = '1;
    if (romIs2k) romMask[ROM_AW-1] = 1'b0;
  end
  assign romAddr = cpuAddr[ROM_AW-1:0] & romMask;

  always_comb begin
    ramSel   = 1'b0;
    romSel   = 1'b0;
    extMemEn = 1'b0;
    if (anyCycle) begin
      if (strobe.bootHold) begin
        if (memRd) romSel   = 1'b1;
        else       extMemEn = 1'b1;
      end else if (memRd && !romOffReg && romWindow) begin
        romSel = 1'b1;
      end else if (onboardHit) begin
        ramSel = 1'b1;
      end else begin
        extMemEn = 1'b1;
      end
    end
  end

  assign bankOn = bankReg;
  assign romOn  = ~romOffReg;

  // R12: responders are mutually exclusive.
  assert_one_responder_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramSel, romSel, extMemEn}));

  // R4: no RAM access during boot-jump.
  assert_no_ram_in_boot_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bootHold |-> !ramSel);

  // R11: idle bus selects nothing.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd || memWr) |-> !(ramSel || romSel || extMemEn));

  // R2: a register write lands on the next edge.
  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgLoad |=> (bankOn == $past(bankData)));

  // R2: without a write, the enables stay put.
  assert_bank_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cfgLoad |=> $stable(bankOn) && $stable(romOn));

  // R8: after release, ROM answers only inside its window with ROM on.
  assert_rom_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    (romSel && !strobe.bootHold) |-> (romOn && romWindow && memRd));

endmodule

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import memmap_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int IO_AW        = 8,
  parameter int BANK_COUNT   = 4,
  parameter int ROM_AW       = 12,
  parameter int ROM_OFF_BIT  = 5,
  parameter int JUMP_BIT     = 6,
  parameter logic [IO_AW-1:0] CTL_PORT = 8'h16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic                  memRd,
  input  logic                  memWr,
  input  logic                  ioWr,
  input  logic [IO_AW-1:0]      ioAddr,
  input  logic [DATA_W-1:0]     ioData,
  input  logic                  romIs2k,
  output logic                  ramSel,
  output logic                  romSel,
  output logic                  extMemEn,
  output logic [ROM_AW-1:0]     romAddr,
  output logic [BANK_COUNT-1:0] bankOn,
  output logic                  romOn,
  output logic                  jumpActive
);

  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << BANK_COUNT) - 1) | DATA_W'(1 << ROM_OFF_BIT) | DATA_W'(1 << JUMP_BIT);

  mapStrobe_t strobe;
  logic       unusedIoBits;

  // Don't-care register bits are deliberately left unconnected.
  assign unusedIoBits = ^(ioData & ~USED_MASK);

  memmap_ctrl #(.IO_AW(IO_AW), .CTL_PORT(CTL_PORT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ioWr       (ioWr),
    .ioAddr     (ioAddr),
    .releaseBit (ioData[JUMP_BIT]),
    .strobe     (strobe)
  );

  memmap_datapath #(.ADDR_W(ADDR_W), .BANK_COUNT(BANK_COUNT), .ROM_AW(ROM_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .bankData   (ioData[BANK_COUNT-1:0]),
    .romOffData (ioData[ROM_OFF_BIT]),
    .cpuAddr    (cpuAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .romIs2k    (romIs2k),
    .ramSel     (ramSel),
    .romSel     (romSel),
    .extMemEn   (extMemEn),
    .romAddr    (romAddr),
    .bankOn     (bankOn),
    .romOn      (romOn)
  );

  assign jumpActive = strobe.bootHold;

endmodule

// File: tb/bankmap_ctrl_test.sv
module bankmap_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        memRd = 1'b0, memWr = 1'b0, ioWr = 1'b0, romIs2k = 1'b0;
  logic [7:0]  ioAddr = '0, ioData = '0;
  logic        ramSel, romSel, extMemEn, romOn, jumpActive;
  logic [11:0] romAddr;
  logic [3:0]  bankOn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state kept as plain integers.
  int mBank;
  int mRomOn;
  int mJump;

  always #10 clk = ~clk;  // 50 MHz

  bankmap_ctrl uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .memRd(memRd), .memWr(memWr),
    .ioWr(ioWr), .ioAddr(ioAddr), .ioData(ioData), .romIs2k(romIs2k),
    .ramSel(ramSel), .romSel(romSel), .extMemEn(extMemEn), .romAddr(romAddr),
    .bankOn(bankOn), .romOn(romOn), .jumpActive(jumpActive)
  );

  function automatic void modelReset();
    mBank = 15; mRomOn = 1; mJump = 1;
  endfunction

  task automatic compare(input string tag);
    int eRam = 0, eRom = 0, eExt = 0, eRa;
    int bank;
    bank = int'(cpuAddr) >> 14;
    if (memRd || memWr) begin
      if (mJump != 0) begin
        if (memRd) eRom = 1; else eExt = 1;
      end else if (memRd && mRomOn != 0 && cpuAddr >= 16'hF000) eRom = 1;
      else if (((mBank >> bank) & 1) != 0) eRam = 1;
      else eExt = 1;
    end
    eRa = int'(cpuAddr) % (romIs2k ? 2048 : 4096);
    checks++;
    if (int'(ramSel) != eRam || int'(romSel) != eRom || int'(extMemEn) != eExt ||
        int'(romAddr) != eRa || int'(bankOn) != mBank || int'(romOn) != mRomOn ||
        int'(jumpActive) != mJump) begin
      errors++;
      $display("FAIL %s: addr=%h ram/rom/ext=%0d%0d%0d exp %0d%0d%0d romAddr=%h exp %h bank=%h exp %h romOn=%0d exp %0d jump=%0d exp %0d",
               tag, cpuAddr, ramSel, romSel, extMemEn, eRam, eRom, eExt, romAddr, eRa[11:0],
               bankOn, mBank[3:0], romOn, mRomOn, jumpActive, mJump);
    end
  endtask

  // One bus cycle: drive at falling edge, check mid-low phase, update model at rising edge.
  task automatic cyc(input logic [15:0] a, input logic rd, input logic wr,
                     input logic iw, input logic [7:0] ia, input logic [7:0] id,
                     input string tag);
    @(negedge clk);
    cpuAddr = a; memRd = rd; memWr = wr; ioWr = iw; ioAddr = ia; ioData = id;
    #2;
    if (!rstN) modelReset();
    compare(tag);
    @(posedge clk);
    if (!rstN) modelReset();
    else if (iw && ia == 8'h16) begin
      mBank  = int'(id[3:0]);
      mRomOn = id[5] ? 0 : 1;
      if (id[6]) mJump = 0;
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(a, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask
  task automatic wr(input logic [15:0] a, input string tag);
    cyc(a, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, tag);
  endtask
  task automatic io(input logic [7:0] port, input logic [7:0] d, input string tag);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, port, d, tag);
  endtask

  initial begin
    modelReset();
    io(8'h16, 8'h60, "R1 reset ignores io write");
    cyc(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R1 reset state");
    @(negedge clk); rstN = 1'b1;
    cyc(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R11 idle after reset");

    // Boot-jump phase
    rd(16'h0000, "R4 boot read 0000");
    rd(16'h4123, "R4 boot read bank1");
    rd(16'hFABC, "R4 boot read top");
    romIs2k = 1'b1;
    rd(16'h0805, "R10 2k mirror");
    rd(16'hFFFF, "R10 2k mirror top");
    romIs2k = 1'b0;
    wr(16'h1234, "R5 boot write external");
    io(8'h17, 8'h40, "R2 wrong port write");
    rd(16'h0000, "R2 wrong port no effect");
    io(8'h16, 8'h0F, "R3 write without release");
    rd(16'h0010, "R3 jump kept");
    io(8'h16, 8'h4F, "R3 release write");

    // Normal map, all banks on, ROM on
    rd(16'h0000, "R6 ram bank0");
    wr(16'h8000, "R6 ram bank2 write");
    rd(16'hE000, "R6 ram bank3 below window");
    rd(16'hF123, "R8 rom over bank3");
    wr(16'hF123, "R8 write under rom to ram");

    // Banks 1 and 3 off
    io(8'h16, 8'h45, "R2 banks 0 and 2");
    rd(16'h4000, "R7 bank1 external");
    wr(16'hC000, "R7 bank3 write external");
    rd(16'hF000, "R8 rom over disabled bank3");
    wr(16'hF000, "R8 window write external");
    rd(16'h9FFF, "R6 bank2 ram");

    // ROM off
    io(8'h16, 8'h6F, "R2 rom off");
    rd(16'hF000, "R9 window ram when rom off");
    io(8'h16, 8'h27, "R3 bit6 clear after release");
    rd(16'hF000, "R9 window external");
    rd(16'h7FFF, "R6 bank1 ram");
    cyc(16'hF000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R11 idle no select");

    // Pseudo-random mix
    begin
      int seed = 32'h1357;
      for (int i = 0; i < 60; i++) begin
        logic [15:0] a;
        logic [1:0]  kind;
        seed = seed * 1103515245 + 12345;
        a = seed[23:8];
        kind = seed[27:26];
        romIs2k = seed[29];
        if (kind == 2'd0)      io(seed[30] ? 8'h16 : 8'h15, seed[15:8] | 8'h40, "R12 random io");
        else if (kind == 2'd1) rd(a, "R12 random read");
        else if (kind == 2'd2) wr(a, "R12 random write");
        else cyc(a, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R11 random idle");
      end
    end

    // Reset again mid-run
    @(negedge clk); rstN = 1'b0;
    cyc(16'h2000, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R1 reset mid-run");
    @(negedge clk); rstN = 1'b1;
    rd(16'h2000, "R4 boot after second reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule